// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Controller

This block runs next to the bit receiver of an I2C target and decides whether the bus is currently at Fast/Standard speed or at High-Speed. Both bus lines are sampled by a fast system clock and passed through counter-based deglitchers. The filtered lines are used to find START, repeated START and STOP conditions and to shift in the first byte of every transfer.

When the first byte after a START in Fast/Standard mode is the high-speed master code, the block switches to High-Speed mode. It pulses a flag and holds its acknowledge inhibit through that byte's acknowledge clock, so the controller sees a NACK. The deglitch window then shrinks to the High-Speed setting. Repeated STARTs keep High-Speed mode, and the byte after each one is handed to the address decoder as the control byte. Only a STOP returns the bus to Fast/Standard mode.

Top module: `i2c_hs_mode_ctrl`

## Requirements
- R1: After reset, hs_mode_o, master_code_seen_o, ack_inhibit_o and ctrl_byte_valid_o are 0 and ctrl_byte_o is 0x00.
- R2: In Fast/Standard mode, a first byte after START whose upper five bits are 00001 sets hs_mode_o to 1 and gives exactly one master_code_seen_o pulse. The lower three bits take no part in the match. Any other first byte leaves hs_mode_o at 0 and gives no pulse.
- R3: ack_inhibit_o is 1 during the high phase of the ninth SCL clock of a recognised master code byte, and 0 during the ninth clock of every other byte.
- R4: In High-Speed mode, the first byte after a repeated START gives one ctrl_byte_valid_o pulse, with the byte on ctrl_byte_o received MSB first (bits 7:1 address, bit 0 R/W). A master code byte never gives ctrl_byte_valid_o.
- R5: In Fast/Standard mode, a first byte that is not the master code is reported as the control byte through one ctrl_byte_valid_o pulse. Later bytes of the same transfer are not reported.
- R6: A START in High-Speed mode keeps hs_mode_o at 1. A following byte of the form 0000_1xxx is then taken as a control byte, with no master_code_seen_o pulse and no ack inhibit.
- R7: A STOP returns hs_mode_o to 0.
- R8: A level change on SCL or SDA is accepted only after it has been stable for HS_FILT_CYC system cycles in High-Speed mode, or FS_FILT_CYC cycles in Fast/Standard mode. Shorter pulses are ignored. With defaults 3 and 12, an SCL pulse of 2 cycles is ignored in both modes, and a pulse of 6 cycles is ignored in Fast/Standard mode but clocks an extra bit in High-Speed mode.
- R9: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. SDA changes while SCL is low change neither the mode nor the condition state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| hs_mode_o | output | 1 | 1 while the bus is in High-Speed mode |
| master_code_seen_o | output | 1 | One-cycle pulse when the master code is recognised |
| ack_inhibit_o | output | 1 | Keeps SDA released through the master code's acknowledge clock |
| ctrl_byte_valid_o | output | 1 | One-cycle pulse: ctrl_byte_o holds the control byte |
| ctrl_byte_o | output | 8 | Control byte for the address decoder |

## Verification
A raw line edge reaches the filtered line after two synchroniser stages plus the active filter count. The condition and bit logic act one cycle later, and the registered outputs follow one cycle after that. That is at most FILT+4 system cycles, which is 16 cycles in Fast/Standard mode and 7 in High-Speed mode. The bench holds every bus phase for at least a half period (32 or 12 cycles), which is longer than this latency. It samples the mode level and ack inhibit at the end of the ninth clock's high phase, reads the pulse counters only after a phase has settled, and clears them before each transfer. Glitch pulses are given exact cycle counts on the falling clock edge, so whether a pulse is ignored or accepted follows from the filter count alone.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  typedef enum logic {
    MODE_FS = 1'b0,
    MODE_HS = 1'b1
  } bus_mode_e;

  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

  function automatic logic is_master_code(input logic [7:0] b);
    return b[7:3] == MCODE_PREFIX;
  endfunction
endpackage

// File: rtl/i2c_hs_deglitch.sv
module i2c_hs_deglitch #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             q_o
);
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      q_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= lim_i - 1'b1) begin
        q_q   <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = q_q;

  // R8
  filt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q != $past(q_q)) |-> (q_q == $past(sync_q[1])));
endmodule

// File: rtl/i2c_hs_cond_det.sv
module i2c_hs_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // Conditions need SCL high on both samples so that an SCL edge is not misread
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_hs_byte_rx.sv
module i2c_hs_byte_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       sda_i,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       ack_slot_o
);
  logic       active_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q  <= 1'b1;
        bit_cnt_q <= '0;
      end else if (stop_i) begin
        active_q  <= 1'b0;
        bit_cnt_q <= '0;
      end else if (active_q) begin
        if (rise_i) begin
          if (bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
            done_q    <= (bit_cnt_q == 4'd7);
          end else if (bit_cnt_q == 4'd8) begin
            bit_cnt_q <= 4'd9;
          end
        end else if (fall_i && bit_cnt_q == 4'd9) begin
          bit_cnt_q <= '0;
        end
      end
    end
  end

  assign byte_done_o = done_q;
  assign byte_o      = shreg_q;
  // Spans from the eighth rising edge to the fall of the ninth clock
  assign ack_slot_o  = active_q && (bit_cnt_q >= 4'd8);

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd9);
  // R4
  byte_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> ack_slot_o);
endmodule

// File: rtl/i2c_hs_mode_ctrl.sv
module i2c_hs_mode_ctrl #(
  parameter int HS_FILT_CYC = 3,
  parameter int FS_FILT_CYC = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       hs_mode_o,
  output logic       master_code_seen_o,
  output logic       ack_inhibit_o,
  output logic       ctrl_byte_valid_o,
  output logic [7:0] ctrl_byte_o
);
  import i2c_hs_pkg::*;

  localparam int MAX_FILT = (HS_FILT_CYC > FS_FILT_CYC) ? HS_FILT_CYC : FS_FILT_CYC;
  localparam int CNT_W    = $clog2(MAX_FILT + 1);
  localparam int N_LINES  = 2;

  bus_mode_e        mode_q;
  logic [CNT_W-1:0] lim;
  logic [N_LINES-1:0] raw, filt;
  logic start, stop, rise, fall;
  logic byte_done, ack_slot;
  logic [7:0] rx_byte;
  logic first_q, mc_q, cv_q, code_ack_q;
  logic [7:0] ctrl_q;

  assign lim = (mode_q == MODE_HS) ? CNT_W'(HS_FILT_CYC) : CNT_W'(FS_FILT_CYC);
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_hs_deglitch #(.CNT_W(CNT_W)) u_dg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .lim_i (lim),
      .q_o   (filt[g])
    );
  end

  i2c_hs_cond_det u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[1]),
    .sda_i     (filt[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(rise),
    .scl_fall_o(fall)
  );

  i2c_hs_byte_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .rise_i     (rise),
    .fall_i     (fall),
    .sda_i      (filt[0]),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte),
    .ack_slot_o (ack_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_FS;
      first_q    <= 1'b0;
      mc_q       <= 1'b0;
      cv_q       <= 1'b0;
      code_ack_q <= 1'b0;
      ctrl_q     <= '0;
    end else begin
      mc_q <= 1'b0;
      cv_q <= 1'b0;
      if (stop) begin
        mode_q     <= MODE_FS;
        first_q    <= 1'b0;
        code_ack_q <= 1'b0;
      end else if (start) begin
        first_q    <= 1'b1;
        code_ack_q <= 1'b0;
      end else if (byte_done && first_q) begin
        first_q <= 1'b0;
        // Code matching applies only while still at Fast/Standard speed
        if (mode_q == MODE_FS && is_master_code(rx_byte)) begin
          mode_q     <= MODE_HS;
          mc_q       <= 1'b1;
          code_ack_q <= 1'b1;
        end else begin
          cv_q   <= 1'b1;
          ctrl_q <= rx_byte;
        end
      end else if (!ack_slot) begin
        code_ack_q <= 1'b0;
      end
    end
  end

  assign hs_mode_o          = (mode_q == MODE_HS);
  assign master_code_seen_o = mc_q;
  assign ack_inhibit_o      = code_ack_q & ack_slot;
  assign ctrl_byte_valid_o  = cv_q;
  assign ctrl_byte_o        = ctrl_q;

  // R7
  hs_stop_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !hs_mode_o);
  // R2
  hs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> master_code_seen_o);
  // R3
  ack_only_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_inhibit_o |-> hs_mode_o);
  // R4
  ctrl_not_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_byte_valid_o |-> !master_code_seen_o);
  // R6
  hs_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_o && start) |=> hs_mode_o);
endmodule

// File: tb/tb_i2c_hs_mode_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_hs_mode_ctrl;
  localparam int HS_LIM = 3;
  localparam int FS_LIM = 12;
  localparam int H_FS   = 32;
  localparam int H_HS   = 12;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic hs_mode, mc_seen, ack_inh, cv;
  logic [7:0] ctrl_byte;

  i2c_hs_mode_ctrl #(.HS_FILT_CYC(HS_LIM), .FS_FILT_CYC(FS_LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .hs_mode_o(hs_mode), .master_code_seen_o(mc_seen), .ack_inhibit_o(ack_inh),
    .ctrl_byte_valid_o(cv), .ctrl_byte_o(ctrl_byte)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, mc_cnt = 0, cv_cnt = 0, hp = H_FS;
  logic [7:0] last_ctrl = '0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (mc_seen) mc_cnt++;
    if (cv) begin cv_cnt++; last_ctrl = ctrl_byte; end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start; wt(hp); sda = 1'b0; wt(hp); scl = 1'b0; endtask
  task automatic bus_rstart;
    wt(hp/2); sda = 1'b1; wt(hp); scl = 1'b1; wt(hp); sda = 1'b0; wt(hp); scl = 1'b0;
  endtask
  task automatic bus_stop;
    wt(hp/2); sda = 1'b0; wt(hp); scl = 1'b1; wt(hp); sda = 1'b1; wt(hp);
  endtask

  // g > 0: an SCL pulse of g cycles is placed in the low phase after the fourth bit
  task automatic send_byte(input logic [7:0] v, input int g, output logic ack_s, output logic hs_s);
    for (int n = 0; n < 8; n++) begin
      wt(hp/2); sda = v[7-n]; wt(hp); scl = 1'b1; wt(hp); scl = 1'b0;
      if (n == 3 && g > 0) begin wt(hp); scl = 1'b1; wt(g); scl = 1'b0; wt(hp); end
    end
    wt(hp/2); sda = 1'b1; wt(hp); scl = 1'b1; wt(hp);
    ack_s = ack_inh; hs_s = hs_mode;
    scl = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a, h;
    logic [7:0] v, gexp;
    wt(5);
    // R1 reset state
    chk(!hs_mode && !mc_seen && !ack_inh && !cv, "R1 flags", {hs_mode, mc_seen, ack_inh, cv}, 0);
    chk(ctrl_byte == 8'h00, "R1 ctrl_byte", ctrl_byte, 0);
    rst_n = 1'b1;
    wt(5);

    // Sweep of first bytes in Fast/Standard mode
    for (int i = 0; i < 40; i++) begin
      bit is_mc;
      v = (i < 32) ? 8'((i << 3) | (i % 8)) : 8'(8 | (i - 32));
      is_mc = (v[7:3] == 5'b00001);
      hp = H_FS; mc_cnt = 0; cv_cnt = 0;
      bus_start();
      send_byte(v, 0, a, h);
      chk(a == is_mc, "R3 ack_inhibit on ninth clock", a, is_mc);
      chk(h == is_mc, "R2 hs_mode after first byte", h, is_mc);
      chk(mc_cnt == int'(is_mc), "R2 master code pulses", mc_cnt, int'(is_mc));
      if (!is_mc) begin
        chk(cv_cnt == 1 && last_ctrl == v, "R5 ctrl byte in FS", last_ctrl, v);
        send_byte(~v, 0, a, h);
        chk(cv_cnt == 1, "R5 later byte not reported", cv_cnt, 1);
        chk(a == 1'b0, "R3 no inhibit on data byte", a, 0);
      end else begin
        chk(cv_cnt == 0, "R4 code not a ctrl byte", cv_cnt, 0);
      end
      bus_stop();
      chk(hs_mode == 1'b0, "R7 stop returns FS", hs_mode, 0);
    end

    // High-Speed session with repeated STARTs
    hp = H_FS; mc_cnt = 0; cv_cnt = 0;
    bus_start();
    send_byte(8'h0D, 0, a, h);
    chk(a == 1'b1 && h == 1'b1, "R2 R3 code 0x0D", {a, h}, 3);
    hp = H_HS;
    bus_rstart();
    send_byte(8'hA5, 0, a, h);
    chk(cv_cnt == 1 && last_ctrl == 8'hA5, "R4 ctrl after Sr", last_ctrl, 8'hA5);
    chk(h == 1'b1 && a == 1'b0, "R6 HS kept, no inhibit", {a, h}, 1);
    // R9 SDA toggles while SCL low
    wt(hp/2); sda = 1'b0; wt(hp); sda = 1'b1; wt(hp);
    chk(hs_mode == 1'b1, "R9 SDA edge with SCL low", hs_mode, 1);
    bus_rstart();
    send_byte(8'h09, 0, a, h);
    chk(cv_cnt == 2 && last_ctrl == 8'h09, "R6 code pattern as ctrl in HS", last_ctrl, 8'h09);
    chk(mc_cnt == 1 && a == 1'b0, "R6 no second code", mc_cnt, 1);
    bus_rstart();
    send_byte(8'h5A, 2, a, h);
    chk(cv_cnt == 3 && last_ctrl == 8'h5A, "R8 2-cycle glitch in HS", last_ctrl, 8'h5A);
    bus_rstart();
    v = 8'h5A;
    gexp = {v[7:4], v[4], v[3:1]};
    send_byte(v, 6, a, h);
    chk(cv_cnt == 4 && last_ctrl == gexp, "R8 6-cycle glitch in HS", last_ctrl, gexp);
    bus_stop();
    chk(hs_mode == 1'b0, "R7 stop after HS", hs_mode, 0);

    // Fast/Standard filter rejects the same 6-cycle pulse
    hp = H_FS; cv_cnt = 0;
    bus_start();
    send_byte(8'h5A, 6, a, h);
    chk(cv_cnt == 1 && last_ctrl == 8'h5A, "R8 6-cycle glitch in FS", last_ctrl, 8'h5A);
    chk(h == 1'b0, "R2 non-code keeps FS", h, 0);
    bus_stop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule